// File: doc/BRIEF.md
# Reconfiguration Stream Sync Monitor

The monitor sits beside a 32-bit configuration word stream that carries one word on each cycle where the valid input is high. Every byte of each word arrives with its bit order reversed. The monitor looks for three kinds of marker in that reversed form: the bus-width probe pair, the sync word and the desync word. From these it tracks whether the stream is inside a synchronized configuration segment, and it reports that state in a 32-bit status word.

The monitor also sequences the handshake around a reconfiguration. A start request raises the isolation (decouple) output and lowers the done flag before any stream word is delivered. A desync word that closes a segment starts a countdown. When the countdown expires, done rises and decouple falls. A stream may hold several sync–desync segments. A sync word that arrives during the countdown cancels it, so the handshake completes only after the last segment.

Top module: `cfg_sync_monitor`

## Requirements
- R1: After reset, status_o is 0xFFFFFF9B, decouple_o is 0, done_o is 1 and width_seen_o is 0.
- R2: An accepted word equal to 0x5599AA66 (sync, byte-bit-reversed 0xAA995566) sets status bit 6 on the next cycle, so status_o reads 0xFFFFFFDB when there is no error.
- R3: Words are accepted only when word_vld_i is high. A stalled cycle changes neither the sync state nor the width-pattern tracking, whatever word_i carries.
- R4: start_i while decouple_o is low makes decouple_o 1 and done_o 0 on the next cycle, and clears width_seen_o.
- R5: An accepted word equal to 0x000000B0 (desync, reversed 0x0000000D) while synchronized clears status bit 6 on the next cycle.
- R6: After a desync that closes a segment, done_o rises and decouple_o falls exactly DONE_DLY clock edges after the edge that accepted the desync, unless the countdown is cancelled.
- R7: A sync word accepted during the countdown cancels it. done_o then stays low until DONE_DLY edges after a later desync.
- R8: Status bit 5 is a sticky error that only reset clears. It is set by a desync accepted while unsynchronized, or by start_i while decouple_o is high. Apart from setting the error, such a start is ignored.
- R9: width_seen_o is set when an accepted 0x000000DD is followed, as the next accepted word, by 0x88440022. Any other order leaves it clear. Once set, it holds until the next accepted start or reset.
- R10: The sync word is honoured whether or not the bus-width pattern came before it.
- R11: decouple_o and done_o are always complements of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Reconfiguration request |
| word_vld_i | input | 1 | word_i carries a stream word this cycle |
| word_i | input | 32 | Byte-bit-reversed configuration word |
| status_o | output | 32 | Status: bit 6 synchronized, bit 5 sticky error, other bits fixed to 0xFFFFFF9B |
| decouple_o | output | 1 | Isolation request |
| done_o | output | 1 | Reconfiguration complete |
| width_seen_o | output | 1 | Bus-width probe pair seen in order |

## Verification
The bench builds the monitor with DONE_DLY set to 3. This keeps every countdown short, so a single vector table can walk two full segments, one cancelled countdown and the error cases. The short delay also lets a sync word land inside the countdown window (R7) and lets the exact rising edge of done be checked cycle by cycle (R6). The width-pattern cases include a stall between the two probe words and a foreign word between them.

// File: rtl/cfgmon_pkg.sv
package cfgmon_pkg;
  localparam int unsigned WORD_W = 32;

  // reverse the bit order inside each byte
  function automatic logic [WORD_W-1:0] rev_bytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W/8; b++)
      for (int i = 0; i < 8; i++)
        r[b*8+i] = w[b*8+7-i];
    return r;
  endfunction

  localparam logic [WORD_W-1:0] SYNC_W   = rev_bytes(32'hAA99_5566);
  localparam logic [WORD_W-1:0] DESYNC_W = rev_bytes(32'h0000_000D);
  localparam logic [WORD_W-1:0] PROBE0_W = rev_bytes(32'h0000_00BB);
  localparam logic [WORD_W-1:0] PROBE1_W = rev_bytes(32'h1122_0044);

  localparam logic [WORD_W-1:0] STAT_BASE = 32'hFFFF_FF9B;
  localparam int unsigned SYNC_BIT = 6;
  localparam int unsigned ERR_BIT  = 5;

  typedef enum logic [1:0] {MK_SYNC, MK_DESYNC, MK_PROBE0, MK_PROBE1} marker_e;
  localparam int unsigned N_MARK = 4;
endpackage

// File: rtl/cfgmon_marker_dec.sv
module cfgmon_marker_dec
  import cfgmon_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [N_MARK-1:0] hit_o
);
  localparam logic [N_MARK-1:0][WORD_W-1:0] PATS = {PROBE1_W, PROBE0_W, DESYNC_W, SYNC_W};

  for (genvar g = 0; g < N_MARK; g++) begin : g_cmp
    assign hit_o[g] = (word_i == PATS[g]);
  end
endmodule

// File: rtl/cfgmon_width_trk.sv
module cfgmon_width_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic acc_i,
  input  logic p0_i,
  input  logic p1_i,
  output logic seen_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      seen_o  <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      seen_o  <= 1'b0;
    end else if (acc_i) begin
      if (armed_q && p1_i) seen_o <= 1'b1;
      armed_q <= p0_i;
    end
  end
endmodule

// File: rtl/cfgmon_done_tmr.sv
module cfgmon_done_tmr #(
  parameter int unsigned DONE_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic cancel_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(DONE_DLY + 1);
  localparam logic [CW-1:0] LOAD_V = CW'(DONE_DLY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cancel_i)        cnt_q <= '0;
    else if (load_i)          cnt_q <= LOAD_V;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign fire_o = (cnt_q == CW'(1)) && !cancel_i;
endmodule

// File: rtl/cfg_sync_monitor.sv
module cfg_sync_monitor
  import cfgmon_pkg::*;
#(
  parameter int unsigned DONE_DLY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              word_vld_i,
  input  logic [31:0]       word_i,
  output logic [31:0]       status_o,
  output logic              decouple_o,
  output logic              done_o,
  output logic              width_seen_o
);
  logic [N_MARK-1:0] hit;
  logic sync_q, err_q, dec_q, done_q;
  logic start_req, sync_hit, desync_ok, desync_bad, fire;

  cfgmon_marker_dec u_dec (.word_i(word_i), .hit_o(hit));

  assign start_req  = start_i && !dec_q;
  assign sync_hit   = word_vld_i && hit[MK_SYNC];
  assign desync_ok  = word_vld_i && hit[MK_DESYNC] && sync_q;
  assign desync_bad = word_vld_i && hit[MK_DESYNC] && !sync_q;

  cfgmon_width_trk u_wid (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(start_req), .acc_i(word_vld_i),
    .p0_i  (hit[MK_PROBE0]), .p1_i(hit[MK_PROBE1]), .seen_o(width_seen_o)
  );

  cfgmon_done_tmr #(.DONE_DLY(DONE_DLY)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(desync_ok),
    .cancel_i(sync_hit || start_req), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      err_q  <= 1'b0;
      dec_q  <= 1'b0;
      done_q <= 1'b1;
    end else begin
      if (sync_hit)       sync_q <= 1'b1;
      else if (desync_ok) sync_q <= 1'b0;
      if (desync_bad || (start_i && dec_q)) err_q <= 1'b1;
      if (start_req) begin
        dec_q  <= 1'b1;
        done_q <= 1'b0;
      end else if (fire) begin
        dec_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_o = STAT_BASE;
    status_o[SYNC_BIT] = sync_q;
    status_o[ERR_BIT]  = err_q;
  end

  assign decouple_o = dec_q;
  assign done_o     = done_q;
endmodule

// File: rtl/cfgmon_chk.sv
module cfgmon_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        word_vld_i,
  input logic [31:0] word_i,
  input logic [31:0] status_o,
  input logic        decouple_o,
  input logic        done_o
);
  a_r2_sync_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_i && word_i == 32'h5599_AA66 |=> status_o[6]);

  a_r3_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_i |=> $stable(status_o[6]));

  a_r4_start_isolates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !decouple_o |=> decouple_o && !done_o);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] |=> status_o[5]);

  a_r11_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decouple_o != done_o);
endmodule

bind cfg_sync_monitor cfgmon_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .word_vld_i(word_vld_i),
  .word_i(word_i), .status_o(status_o), .decouple_o(decouple_o), .done_o(done_o)
);

// File: tb/sim_cfg_sync_monitor.sv
module sim_cfg_sync_monitor;
  localparam int unsigned DLY = 3;
  localparam int unsigned NV  = 30;

  typedef struct packed {
    logic        st;
    logic        vld;
    logic [31:0] wd;
    logic [31:0] stat;
    logic        dec;
    logic        dn;
    logic        wid;
  } vec_t;

  localparam logic [31:0] SY = 32'h5599_AA66, DS = 32'h0000_00B0;
  localparam logic [31:0] P0 = 32'h0000_00DD, P1 = 32'h8844_0022;
  localparam logic [31:0] NS = 32'hFFFF_FF9B, YS = 32'hFFFF_FFDB, NE = 32'hFFFF_FFBB;

  // checked after the edge that applies the vector
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 32'h0,  NS, 1'b1, 1'b0, 1'b0},  // 0  R4 start
    '{1'b0, 1'b1, P0,     NS, 1'b1, 1'b0, 1'b0},  // 1
    '{1'b0, 1'b1, P1,     NS, 1'b1, 1'b0, 1'b1},  // 2  R9 in order
    '{1'b0, 1'b1, SY,     YS, 1'b1, 1'b0, 1'b1},  // 3  R2
    '{1'b0, 1'b1, 32'h12345678, YS, 1'b1, 1'b0, 1'b1}, // 4
    '{1'b0, 1'b0, DS,     YS, 1'b1, 1'b0, 1'b1},  // 5  R3 stalled desync
    '{1'b0, 1'b1, DS,     NS, 1'b1, 1'b0, 1'b1},  // 6  R5
    '{1'b0, 1'b0, 32'h0,  NS, 1'b1, 1'b0, 1'b1},  // 7
    '{1'b0, 1'b0, 32'h0,  NS, 1'b1, 1'b0, 1'b1},  // 8
    '{1'b0, 1'b0, 32'h0,  NS, 1'b0, 1'b1, 1'b1},  // 9  R6 third edge
    '{1'b1, 1'b0, 32'h0,  NS, 1'b1, 1'b0, 1'b0},  // 10 R4 clears width
    '{1'b0, 1'b1, SY,     YS, 1'b1, 1'b0, 1'b0},  // 11 R10 no probe
    '{1'b0, 1'b1, DS,     NS, 1'b1, 1'b0, 1'b0},  // 12
    '{1'b0, 1'b1, SY,     YS, 1'b1, 1'b0, 1'b0},  // 13 R7 cancel
    '{1'b0, 1'b0, 32'h0,  YS, 1'b1, 1'b0, 1'b0},  // 14
    '{1'b0, 1'b0, 32'h0,  YS, 1'b1, 1'b0, 1'b0},  // 15
    '{1'b0, 1'b0, 32'h0,  YS, 1'b1, 1'b0, 1'b0},  // 16 R7 still low
    '{1'b0, 1'b1, DS,     NS, 1'b1, 1'b0, 1'b0},  // 17
    '{1'b0, 1'b0, 32'h0,  NS, 1'b1, 1'b0, 1'b0},  // 18
    '{1'b0, 1'b0, 32'h0,  NS, 1'b1, 1'b0, 1'b0},  // 19
    '{1'b0, 1'b0, 32'h0,  NS, 1'b0, 1'b1, 1'b0},  // 20 R6
    '{1'b0, 1'b1, DS,     NE, 1'b0, 1'b1, 1'b0},  // 21 R8 desync unsynced
    '{1'b1, 1'b0, 32'h0,  NE, 1'b1, 1'b0, 1'b0},  // 22
    '{1'b1, 1'b0, 32'h0,  NE, 1'b1, 1'b0, 1'b0},  // 23 R8 start busy
    '{1'b0, 1'b1, P0,     NE, 1'b1, 1'b0, 1'b0},  // 24
    '{1'b0, 1'b1, 32'h1,  NE, 1'b1, 1'b0, 1'b0},  // 25
    '{1'b0, 1'b1, P1,     NE, 1'b1, 1'b0, 1'b0},  // 26 R9 broken order
    '{1'b0, 1'b1, P0,     NE, 1'b1, 1'b0, 1'b0},  // 27
    '{1'b0, 1'b0, 32'h0,  NE, 1'b1, 1'b0, 1'b0},  // 28 R3 stall keeps armed
    '{1'b0, 1'b1, P1,     NE, 1'b1, 1'b0, 1'b1}   // 29 R9
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic st = 1'b0, vld = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] stat;
  logic dec, dn, wid;
  int n_chk = 0, n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  cfg_sync_monitor #(.DONE_DLY(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(st), .word_vld_i(vld), .word_i(wd),
    .status_o(stat), .decouple_o(dec), .done_o(dn), .width_seen_o(wid)
  );

  task automatic chk(input string rq, input logic [34:0] act, input logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 in reset", {stat, dec, dn, wid}, {NS, 1'b0, 1'b1, 1'b0});
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {stat, dec, dn, wid}, {NS, 1'b0, 1'b1, 1'b0});
    st = TBL[0].st; vld = TBL[0].vld; wd = TBL[0].wd;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk($sformatf("vector %0d (R2-R10)", i), {stat, dec, dn, wid},
          {TBL[i].stat, TBL[i].dec, TBL[i].dn, TBL[i].wid});
      if (i + 1 < NV) begin
        st = TBL[i+1].st; vld = TBL[i+1].vld; wd = TBL[i+1].wd;
      end else begin
        st = 1'b0; vld = 1'b0; wd = '0;
      end
    end
    // R8: error survives a fresh sync, cleared only by reset
    vld = 1'b1; wd = SY;
    @(negedge clk);
    vld = 1'b0;
    chk("R8 sticky with sync", stat, 32'hFFFF_FFFB);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 reset clears error", {stat, dec, dn, wid}, {NS, 1'b0, 1'b1, 1'b0});
    rst_ni = 1'b1;
    // R3: stalled sync word does nothing
    vld = 1'b0; wd = SY;
    @(negedge clk);
    chk("R3 stalled sync", stat, NS);
    // R6: countdown also runs without a start
    vld = 1'b1; wd = SY;
    @(negedge clk);
    wd = DS;
    @(negedge clk);
    vld = 1'b0;
    chk("R5 desync", {stat, dec, dn}, {NS, 1'b0, 1'b1});
    finish_run();
  end
endmodule